// File: doc/BRIEF.md
# Bracket Pulse Spacing Decoder

This block decides whether two detected reply pulses sit apart by the bracket spacing. Its input is a synchronous detected-pulse flag that is already thresholded, so it is valid on any clock cycle. When a pulse arrives and no earlier start is still blocking new ones, the block opens a gate window and begins a longer trigger-inhibit period. For as long as the inhibit lasts, a gated oscillator runs from a phase that restarts at the start event and produces narrow sample pulses.

A later pulse is taken as the second bracket only under three conditions together: the window has already closed, the pulse is present, and a sample pulse is active. When all three hold, the block emits an output pulse of fixed width. It gives at most one such pulse per start event. All durations are parameters counted in clock cycles. The defaults assume a 100 MHz clock: a 1900-cycle window, a 2400-cycle inhibit, a 185-cycle oscillator period, a 35-cycle sample pulse and a 20-cycle output pulse.

Top module: `bracket_spacing_decoder`

## Requirements
- R1: While `rst` is high, and on the cycle after it, `window_o`, `inhibit_o`, `sample_o` and `pair_ok_o` are all low, whatever `pulse_det_i` does.
- R2: A cycle with `pulse_det_i` high and `inhibit_o` low is a start. Number the cycles after that start edge k = 0, 1, 2 and so on. `window_o` is high for k < WIN_CYC and `inhibit_o` is high for k < INH_CYC.
- R3: `pulse_det_i` has no effect on the window or on the inhibit timing while `inhibit_o` is high. Pulses that arrive while the window is open do not restart it.
- R4: `sample_o` is high only for k < INH_CYC, and only when (k mod PER_CYC) < SMP_CYC - SMP_CYC/2 or (k mod PER_CYC) >= PER_CYC - SMP_CYC/2. This places each sample pulse around a multiple of the period. `sample_o` is low whenever `inhibit_o` is low.
- R5: Suppose that at inhibit cycle kf, `pulse_det_i` is high, `window_o` is low, `sample_o` is high and no decode has yet happened since the start. Then `pair_ok_o` is high for exactly OUT_CYC cycles, starting one cycle later.
- R6: A pulse at a cycle where the window is still open, or where no sample pulse is active, produces no output pulse.
- R7: Only one output pulse is produced per start event. Any further coincident pulses, or a pulse held high across several sample cycles, add nothing.
- R8: A pulse on the first cycle with `inhibit_o` low, k = INH_CYC, starts a new window. A pulse at k = INH_CYC - 1 does not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pulse_det_i | input | 1 | Thresholded detected-pulse flag |
| pair_ok_o | output | 1 | Decoded bracket pair pulse, OUT_CYC wide |
| window_o | output | 1 | Gate window active |
| inhibit_o | output | 1 | Start trigger inhibited; oscillator running |
| sample_o | output | 1 | Sample pulse from the gated oscillator |

## Verification
`window_o`, `inhibit_o` and `sample_o` take their k = 0 values on the same edge that registers the start. `pair_ok_o` rises on the edge that registers a qualifying pulse, and it stays high for OUT_CYC cycles. The bench drives inputs on falling edges and samples one time unit after each rising edge, so the value it reads after the edge of iteration j belongs to k = j. It sweeps the second pulse across every inhibit cycle and compares each output on every cycle with a closed-form expectation built from k.

// File: rtl/bpd_pkg.sv
package bpd_pkg;

    // Observable timing state of one bracket session
    typedef struct packed {
        logic win;
        logic inh;
        logic smp;
    } bpd_timing_t;

    // Where a session currently stands
    typedef enum logic [1:0] {
        SESS_IDLE = 2'd0,
        SESS_OPEN = 2'd1,
        SESS_LATE = 2'd2
    } bpd_sess_e;

    function automatic bpd_sess_e sess_of(input bpd_timing_t t);
        if (!t.inh)
            return SESS_IDLE;
        else if (t.win)
            return SESS_OPEN;
        else
            return SESS_LATE;
    endfunction

    // True when an oscillator phase lies inside a sample pulse centred on phase 0
    function automatic logic phase_hit(input int unsigned ph,
                                       input int unsigned per,
                                       input int unsigned sw);
        int unsigned hi;
        int unsigned lo;
        hi = sw / 2;
        lo = sw - hi;
        return (ph < lo) || (ph >= per - hi);
    endfunction

endpackage

// File: rtl/bpd_down_timer.sv
module bpd_down_timer #(
    parameter int unsigned LEN = 1900
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    output logic active
);
    localparam int unsigned CW = $clog2(LEN + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load)
            cnt_q <= CW'(LEN);
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign active = (cnt_q != '0);
endmodule

// File: rtl/bpd_sample_osc.sv
module bpd_sample_osc
    import bpd_pkg::*;
#(
    parameter int unsigned PERIOD = 185,
    parameter int unsigned WIDTH  = 35
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    input  logic run,
    output logic sample
);
    localparam int unsigned PW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
    localparam logic [PW-1:0] LAST = PW'(PERIOD - 1);

    logic [PW-1:0] phase_q;

    always_ff @(posedge clk) begin
        if (rst)
            phase_q <= '0;
        else if (restart)
            phase_q <= '0;
        else if (run)
            phase_q <= (phase_q == LAST) ? '0 : phase_q + 1'b1;
        else
            phase_q <= '0;
    end

    assign sample = run && phase_hit(32'(phase_q), PERIOD, WIDTH);
endmodule

// File: rtl/bpd_pulse_gen.sv
module bpd_pulse_gen #(
    parameter int unsigned OUT_W = 20
) (
    input  logic clk,
    input  logic rst,
    input  logic arm,
    input  logic fire_req,
    output logic pulse
);
    localparam int unsigned CW = $clog2(OUT_W + 1);

    logic [CW-1:0] cnt_q;
    logic          done_q;
    logic          fire_go;

    assign fire_go = fire_req && !done_q;

    always_ff @(posedge clk) begin
        if (rst)
            done_q <= 1'b0;
        else if (arm)
            done_q <= 1'b0;
        else if (fire_go)
            done_q <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (fire_go)
            cnt_q <= CW'(OUT_W);
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign pulse = (cnt_q != '0);
endmodule

// File: rtl/bracket_spacing_decoder.sv
module bracket_spacing_decoder
    import bpd_pkg::*;
#(
    parameter int unsigned WIN_CYC = 1900,
    parameter int unsigned INH_CYC = 2400,
    parameter int unsigned PER_CYC = 185,
    parameter int unsigned SMP_CYC = 35,
    parameter int unsigned OUT_CYC = 20
) (
    input  logic clk,
    input  logic rst,
    input  logic pulse_det_i,
    output logic pair_ok_o,
    output logic window_o,
    output logic inhibit_o,
    output logic sample_o
);
    bpd_timing_t tm;
    bpd_sess_e   sess;
    logic        start;
    logic        fire_req;

    // Only the start path honours the inhibit; the decode path sees the raw pulse
    assign start    = pulse_det_i && !tm.inh;
    assign sess     = sess_of(tm);
    assign fire_req = pulse_det_i && (sess == SESS_LATE) && tm.smp;

    bpd_down_timer #(.LEN(WIN_CYC)) u_win (
        .clk    (clk),
        .rst    (rst),
        .load   (start),
        .active (tm.win)
    );

    bpd_down_timer #(.LEN(INH_CYC)) u_inh (
        .clk    (clk),
        .rst    (rst),
        .load   (start),
        .active (tm.inh)
    );

    bpd_sample_osc #(.PERIOD(PER_CYC), .WIDTH(SMP_CYC)) u_osc (
        .clk     (clk),
        .rst     (rst),
        .restart (start),
        .run     (tm.inh),
        .sample  (tm.smp)
    );

    bpd_pulse_gen #(.OUT_W(OUT_CYC)) u_out (
        .clk      (clk),
        .rst      (rst),
        .arm      (start),
        .fire_req (fire_req),
        .pulse    (pair_ok_o)
    );

    assign window_o  = tm.win;
    assign inhibit_o = tm.inh;
    assign sample_o  = tm.smp;
endmodule

// File: rtl/bracket_spacing_decoder_chk.sv
module bracket_spacing_decoder_chk #(
    parameter int unsigned OUT_CYC = 20
) (
    input logic clk,
    input logic rst,
    input logic pulse_det_i,
    input logic pair_ok_o,
    input logic window_o,
    input logic inhibit_o,
    input logic sample_o
);
    logic        start;
    logic        rise;
    logic        out_q;
    logic [15:0] run_q;
    logic [3:0]  dec_cnt_q;

    assign start = pulse_det_i && !inhibit_o;
    assign rise  = pair_ok_o && !out_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q     <= 1'b0;
            run_q     <= '0;
            dec_cnt_q <= '0;
        end else begin
            out_q     <= pair_ok_o;
            run_q     <= pair_ok_o ? run_q + 16'd1 : 16'd0;
            if (start)
                dec_cnt_q <= '0;
            else if (rise && dec_cnt_q != 4'hF)
                dec_cnt_q <= dec_cnt_q + 4'd1;
        end
    end

    // R1
    reset_clears_chk: assert property (@(posedge clk)
        rst |=> !window_o && !inhibit_o && !sample_o && !pair_ok_o);

    // R2
    start_loads_chk: assert property (@(posedge clk) disable iff (rst)
        start |=> window_o && inhibit_o);

    // R2
    window_in_inhibit_chk: assert property (@(posedge clk) disable iff (rst)
        window_o |-> inhibit_o);

    // R3
    no_restart_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(window_o) |-> $past(pulse_det_i && !inhibit_o));

    // R4
    sample_gated_chk: assert property (@(posedge clk) disable iff (rst)
        !inhibit_o |-> !sample_o);

    // R5
    decode_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(pair_ok_o) |-> $past(pulse_det_i && !window_o && sample_o));

    // R5
    out_width_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(pair_ok_o) |-> run_q == 16'(OUT_CYC));

    // R7
    one_decode_chk: assert property (@(posedge clk) disable iff (rst)
        dec_cnt_q <= 4'd1);
endmodule

bind bracket_spacing_decoder bracket_spacing_decoder_chk #(.OUT_CYC(OUT_CYC)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .pulse_det_i (pulse_det_i),
    .pair_ok_o   (pair_ok_o),
    .window_o    (window_o),
    .inhibit_o   (inhibit_o),
    .sample_o    (sample_o)
);

// File: tb/tb_bracket_spacing_decoder.sv
module tb_bracket_spacing_decoder;
    localparam int CLK_PERIOD = 10;
    localparam int WIN = 20;
    localparam int INH = 40;
    localparam int PER = 9;
    localparam int SMP = 3;
    localparam int OW  = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic det = 1'b0;
    logic pair_ok, win, inh, smp;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bracket_spacing_decoder #(
        .WIN_CYC(WIN), .INH_CYC(INH), .PER_CYC(PER), .SMP_CYC(SMP), .OUT_CYC(OW)
    ) dut (
        .clk(clk), .rst(rst), .pulse_det_i(det),
        .pair_ok_o(pair_ok), .window_o(win), .inhibit_o(inh), .sample_o(smp)
    );

    function automatic bit exp_smp(input int k);
        int ph;
        if (k < 0 || k >= INH) return 1'b0;
        ph = k % PER;
        return (ph < SMP - SMP/2) || (ph >= PER - SMP/2);
    endfunction

    task automatic check(input string tag, input string what, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
        end
    endtask

    // drive det on the falling edge, then sample just after the rising edge
    task automatic step(input logic d);
        @(negedge clk);
        det = d;
        @(posedge clk);
        #1;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0);
    endtask

    initial begin
        // R1: reset holds everything low even with pulses present
        for (int i = 0; i < 3; i++) begin
            step(1'b1);
            check("R1", "window", win, 1'b0);
            check("R1", "inhibit", inh, 1'b0);
            check("R1", "sample", smp, 1'b0);
            check("R1", "pair", pair_ok, 1'b0);
        end
        @(negedge clk);
        rst = 1'b0;
        det = 1'b0;
        idle(2);

        // R2 R3 R4 R5 R6: sweep the second pulse over every inhibit cycle
        for (int d = 1; d <= INH; d++) begin
            int  kf;
            bit  fire;
            kf = d - 1;
            fire = (kf >= WIN) && exp_smp(kf);
            for (int j = 0; j <= INH + OW + 2; j++) begin
                step((j == 0) || (j == d));
                check((d < WIN) ? "R3" : "R2", "window", win, (j < WIN));
                check((d == INH) ? "R8" : "R2", "inhibit", inh, (j < INH));
                check("R4", "sample", smp, exp_smp(j));
                check(fire ? "R5" : "R6", "pair", pair_ok, fire && (j >= d) && (j < d + OW));
            end
        end

        // R7: held pulse across a sample, then a second coincidence later
        for (int j = 0; j <= INH + OW + 2; j++) begin
            bit dj;
            dj = (j == 0) || (j >= 27 && j <= 29) || (j == 36);
            step(dj);
            check("R7", "pair", pair_ok, (j >= 27) && (j < 27 + OW));
        end

        // R8: a pulse on the first uninhibited cycle starts a new window
        for (int j = 0; j <= INH + 1; j++) begin
            step((j == 0) || (j == INH + 1));
            if (j == INH) check("R8", "inhibit", inh, 1'b0);
        end
        check("R8", "window", win, 1'b1);
        check("R8", "inhibit", inh, 1'b1);
        check("R8", "sample", smp, exp_smp(0));
        idle(INH + 2);

        // R1: a reset in mid-session clears all state
        step(1'b1);
        idle(WIN + 5);
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #1;
        check("R1", "window", win, 1'b0);
        check("R1", "inhibit", inh, 1'b0);
        check("R1", "sample", smp, 1'b0);
        check("R1", "pair", pair_ok, 1'b0);
        @(negedge clk);
        rst = 1'b0;

        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            finished = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule